// File: doc/BRIEF.md
# Multi-Cycle Instruction Sequencer

This block is the control unit for a multi-cycle 32-bit datapath. The datapath has one memory, one ALU and one register file. The sequencer takes the 6-bit opcode field (instruction bits 31 to 26) from the instruction register. It steps the datapath through a different number of cycles for each instruction class: word load, word store, register-register arithmetic (add, sub, and, or, slt), branch-if-equal and jump.

Every instruction starts with two shared states. Fetch (`ST_FETCH`) reads the instruction and adds 4 to the program counter. Decode (`ST_DECODE`) reads the source registers and computes the branch target ahead of time. After decode, the machine takes a path that depends on the instruction class, and every path ends back in fetch:

- Load: `ST_ADDR` → `ST_LOAD` → `ST_LDWB`
- Store: `ST_ADDR` → `ST_STORE`
- Arithmetic: `ST_EXEC` → `ST_ALUWB`
- Branch: `ST_BRANCH`
- Jump: `ST_JUMP`
- Unrecognised opcode: straight back to fetch

The outputs are a Moore function of the state. The whole control word sits in a register that is loaded with the encoding of the next state, so the strobes have no combinational path from the opcode input.

Top module: `seqc_top`

## Requirements
- R1: While `rst` is high at a rising edge, the machine enters fetch. In the following cycle the outputs equal the fetch word.
- R2: The fetch word asserts `mem_rd`, `ir_wr` and `pc_wr`, with `addr_from_alu`=0, `alu_a_sel`=0, `alu_b_sel`=01 (constant 4), `alu_op`=00 (add) and `pc_src`=00 (live ALU result). All other strobes are 0.
- R3: The cycle after fetch is always decode. Decode sets `alu_a_sel`=0, `alu_b_sel`=11 (shifted immediate) and `alu_op`=00, and asserts no write or read strobe.
- R4: Opcode 100011 (load) takes 5 cycles:
  - address: `alu_a_sel`=1, `alu_b_sel`=10, `alu_op`=00
  - memory read: `mem_rd`=1, `addr_from_alu`=1
  - write-back: `reg_wr`=1, `wb_from_mem`=1, `dst_from_rd`=0
- R5: Opcode 101011 (store) takes 4 cycles: the same address state, then a state with `mem_wr`=1 and `addr_from_alu`=1.
- R6: Opcode 000000 (register arithmetic) takes 4 cycles:
  - execute: `alu_a_sel`=1, `alu_b_sel`=00, `alu_op`=10 (function field)
  - write-back: `reg_wr`=1, `dst_from_rd`=1, `wb_from_mem`=0
- R7: Opcode 000100 (branch if equal) takes 3 cycles. Its last state sets `alu_a_sel`=1, `alu_b_sel`=00, `alu_op`=01 (subtract), `pc_wr_cond`=1 and `pc_src`=01 (ALU result register).
- R8: Opcode 000010 (jump) takes 3 cycles. Its last state sets `pc_wr`=1 and `pc_src`=10 (jump target).
- R9: Any other opcode seen in decode returns the machine to fetch in the next cycle, with no write strobe asserted along the way.
- R10: The opcode input has no effect on the outputs, or on the path taken, in any state other than decode and address.
- R11: `mem_rd` and `mem_wr` are never high together, and `pc_wr` and `pc_wr_cond` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | OPC_W | Opcode field of the instruction register |
| pc_wr_cond | output | 1 | PC write if the ALU zero flag is set |
| pc_wr | output | 1 | Unconditional PC write |
| addr_from_alu | output | 1 | Memory address from the ALU result register (0 = PC) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| wb_from_mem | output | 1 | Register write data from the memory data register (0 = ALU result register) |
| ir_wr | output | 1 | Instruction register load |
| pc_src | output | SEL_W | PC source: 00 live ALU, 01 ALU result register, 10 jump target |
| alu_op | output | SEL_W | 00 add, 01 subtract, 10 use function field |
| alu_b_sel | output | SEL_W | ALU B: 00 B register, 01 constant 4, 10 immediate, 11 immediate shifted by 2 |
| alu_a_sel | output | 1 | ALU A: 0 PC, 1 A register |
| reg_wr | output | 1 | Register file write |
| dst_from_rd | output | 1 | Destination register from rd (0 = rt) |

## Verification
The bench builds the block with its default parameters: a 6-bit opcode, 2-bit selects and the usual encodings for the five instruction classes. Those defaults let a single run reach every state and every transition, and also the fall-through for an unused code (111111). Because the opcode width matches the real instruction field, the bench can change the opcode in the middle of an instruction, outside decode and address, and show that neither the strobes nor the path react.

// File: rtl/seqc_pkg.sv
package seqc_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_DECODE,
        ST_ADDR,
        ST_LOAD,
        ST_LDWB,
        ST_STORE,
        ST_EXEC,
        ST_ALUWB,
        ST_BRANCH,
        ST_JUMP
    } state_e;

    typedef enum logic [2:0] {
        CL_LOAD,
        CL_STORE,
        CL_REG,
        CL_BRANCH,
        CL_JUMP,
        CL_OTHER
    } class_e;

    localparam logic [SEL_W-1:0] ALU_ADD  = 2'b00;
    localparam logic [SEL_W-1:0] ALU_SUB  = 2'b01;
    localparam logic [SEL_W-1:0] ALU_FUNC = 2'b10;

    localparam logic [SEL_W-1:0] B_REG   = 2'b00;
    localparam logic [SEL_W-1:0] B_FOUR  = 2'b01;
    localparam logic [SEL_W-1:0] B_IMM   = 2'b10;
    localparam logic [SEL_W-1:0] B_IMMSH = 2'b11;

    localparam logic [SEL_W-1:0] PC_ALU  = 2'b00;
    localparam logic [SEL_W-1:0] PC_AOUT = 2'b01;
    localparam logic [SEL_W-1:0] PC_JMP  = 2'b10;

    typedef struct packed {
        logic             pc_wr_cond;
        logic             pc_wr;
        logic             addr_from_alu;
        logic             mem_rd;
        logic             mem_wr;
        logic             wb_from_mem;
        logic             ir_wr;
        logic [SEL_W-1:0] pc_src;
        logic [SEL_W-1:0] alu_op;
        logic [SEL_W-1:0] alu_b_sel;
        logic             alu_a_sel;
        logic             reg_wr;
        logic             dst_from_rd;
    } ctrl_t;

endpackage

// File: rtl/seqc_opclass.sv
module seqc_opclass
    import seqc_pkg::*;
#(
    parameter int             OPC_W  = 6,
    parameter logic [OPC_W-1:0] OP_LOAD  = 6'b100011,
    parameter logic [OPC_W-1:0] OP_STORE = 6'b101011,
    parameter logic [OPC_W-1:0] OP_REG   = 6'b000000,
    parameter logic [OPC_W-1:0] OP_BEQ   = 6'b000100,
    parameter logic [OPC_W-1:0] OP_JUMP  = 6'b000010
) (
    input  logic [OPC_W-1:0] opcode,
    output class_e           op_class
);

    always_comb begin
        if (opcode == OP_LOAD)       op_class = CL_LOAD;
        else if (opcode == OP_STORE) op_class = CL_STORE;
        else if (opcode == OP_REG)   op_class = CL_REG;
        else if (opcode == OP_BEQ)   op_class = CL_BRANCH;
        else if (opcode == OP_JUMP)  op_class = CL_JUMP;
        else                         op_class = CL_OTHER;
    end

endmodule

// File: rtl/seqc_next.sv
module seqc_next
    import seqc_pkg::*;
(
    input  state_e state_q,
    input  class_e op_class,
    output state_e state_d
);

    always_comb begin
        state_d = ST_FETCH;
        unique case (state_q)
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: begin
                unique case (op_class)
                    CL_LOAD, CL_STORE: state_d = ST_ADDR;
                    CL_REG:            state_d = ST_EXEC;
                    CL_BRANCH:         state_d = ST_BRANCH;
                    CL_JUMP:           state_d = ST_JUMP;
                    default:           state_d = ST_FETCH;
                endcase
            end
            ST_ADDR:   state_d = (op_class == CL_STORE) ? ST_STORE : ST_LOAD;
            ST_LOAD:   state_d = ST_LDWB;
            ST_EXEC:   state_d = ST_ALUWB;
            ST_LDWB, ST_STORE, ST_ALUWB, ST_BRANCH, ST_JUMP:
                       state_d = ST_FETCH;
            default:   state_d = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/seqc_encode.sv
module seqc_encode
    import seqc_pkg::*;
(
    input  state_e state,
    output ctrl_t  ctrl
);

    always_comb begin
        ctrl = '0;
        unique case (state)
            ST_FETCH: begin
                ctrl.mem_rd    = 1'b1;
                ctrl.ir_wr     = 1'b1;
                ctrl.pc_wr     = 1'b1;
                ctrl.alu_b_sel = B_FOUR;
                ctrl.alu_op    = ALU_ADD;
                ctrl.pc_src    = PC_ALU;
            end
            ST_DECODE: begin
                ctrl.alu_b_sel = B_IMMSH;
                ctrl.alu_op    = ALU_ADD;
            end
            ST_ADDR: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = B_IMM;
                ctrl.alu_op    = ALU_ADD;
            end
            ST_LOAD: begin
                ctrl.mem_rd        = 1'b1;
                ctrl.addr_from_alu = 1'b1;
            end
            ST_LDWB: begin
                ctrl.reg_wr      = 1'b1;
                ctrl.wb_from_mem = 1'b1;
            end
            ST_STORE: begin
                ctrl.mem_wr        = 1'b1;
                ctrl.addr_from_alu = 1'b1;
            end
            ST_EXEC: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = B_REG;
                ctrl.alu_op    = ALU_FUNC;
            end
            ST_ALUWB: begin
                ctrl.reg_wr      = 1'b1;
                ctrl.dst_from_rd = 1'b1;
            end
            ST_BRANCH: begin
                ctrl.alu_a_sel  = 1'b1;
                ctrl.alu_b_sel  = B_REG;
                ctrl.alu_op     = ALU_SUB;
                ctrl.pc_wr_cond = 1'b1;
                ctrl.pc_src     = PC_AOUT;
            end
            ST_JUMP: begin
                ctrl.pc_wr  = 1'b1;
                ctrl.pc_src = PC_JMP;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/seqc_top.sv
module seqc_top
    import seqc_pkg::*;
#(
    parameter int               OPC_W    = 6,
    parameter logic [OPC_W-1:0] OP_LOAD  = 6'b100011,
    parameter logic [OPC_W-1:0] OP_STORE = 6'b101011,
    parameter logic [OPC_W-1:0] OP_REG   = 6'b000000,
    parameter logic [OPC_W-1:0] OP_BEQ   = 6'b000100,
    parameter logic [OPC_W-1:0] OP_JUMP  = 6'b000010
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    output logic             pc_wr_cond,
    output logic             pc_wr,
    output logic             addr_from_alu,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             wb_from_mem,
    output logic             ir_wr,
    output logic [SEL_W-1:0] pc_src,
    output logic [SEL_W-1:0] alu_op,
    output logic [SEL_W-1:0] alu_b_sel,
    output logic             alu_a_sel,
    output logic             reg_wr,
    output logic             dst_from_rd
);

    state_e state_q;
    state_e state_d;
    class_e op_class;
    ctrl_t  ctrl_d;
    ctrl_t  ctrl_q;
    ctrl_t  ctrl_fetch;

    seqc_opclass #(
        .OPC_W    (OPC_W),
        .OP_LOAD  (OP_LOAD),
        .OP_STORE (OP_STORE),
        .OP_REG   (OP_REG),
        .OP_BEQ   (OP_BEQ),
        .OP_JUMP  (OP_JUMP)
    ) u_class (
        .opcode   (opcode),
        .op_class (op_class)
    );

    seqc_next u_next (
        .state_q  (state_q),
        .op_class (op_class),
        .state_d  (state_d)
    );

    // Control word for the state being entered, registered below.
    seqc_encode u_enc (
        .state (state_d),
        .ctrl  (ctrl_d)
    );

    seqc_encode u_enc_rst (
        .state (ST_FETCH),
        .ctrl  (ctrl_fetch)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= ctrl_fetch;
        else     ctrl_q <= ctrl_d;
    end

    assign pc_wr_cond    = ctrl_q.pc_wr_cond;
    assign pc_wr         = ctrl_q.pc_wr;
    assign addr_from_alu = ctrl_q.addr_from_alu;
    assign mem_rd        = ctrl_q.mem_rd;
    assign mem_wr        = ctrl_q.mem_wr;
    assign wb_from_mem   = ctrl_q.wb_from_mem;
    assign ir_wr         = ctrl_q.ir_wr;
    assign pc_src        = ctrl_q.pc_src;
    assign alu_op        = ctrl_q.alu_op;
    assign alu_b_sel     = ctrl_q.alu_b_sel;
    assign alu_a_sel     = ctrl_q.alu_a_sel;
    assign reg_wr        = ctrl_q.reg_wr;
    assign dst_from_rd   = ctrl_q.dst_from_rd;

endmodule

// File: rtl/seqc_chk.sv
module seqc_chk (
    input logic       clk,
    input logic       rst,
    input logic       pc_wr_cond,
    input logic       pc_wr,
    input logic       addr_from_alu,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       wb_from_mem,
    input logic       ir_wr,
    input logic [1:0] pc_src,
    input logic [1:0] alu_op,
    input logic [1:0] alu_b_sel,
    input logic       alu_a_sel,
    input logic       reg_wr,
    input logic       dst_from_rd
);

    AST_MEM_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr)); // R11

    AST_PC_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(pc_wr && pc_wr_cond)); // R11

    AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (rst)
        ir_wr |=> (!ir_wr && alu_b_sel == 2'b11 && !alu_a_sel && !reg_wr && !mem_wr)); // R3

    AST_LOAD_TO_WB: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && addr_from_alu) |=> (reg_wr && wb_from_mem && !dst_from_rd)); // R4

    AST_STORE_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> ir_wr); // R5

    AST_WB_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> ir_wr); // R4

    AST_EXEC_TO_WB: assert property (@(posedge clk) disable iff (rst)
        (alu_op == 2'b10) |=> (reg_wr && dst_from_rd)); // R6

    AST_BRANCH_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
        pc_wr_cond |=> ir_wr); // R7

    AST_JUMP_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
        (pc_wr && pc_src == 2'b10) |=> ir_wr); // R8

endmodule

bind seqc_top seqc_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .pc_wr_cond    (pc_wr_cond),
    .pc_wr         (pc_wr),
    .addr_from_alu (addr_from_alu),
    .mem_rd        (mem_rd),
    .mem_wr        (mem_wr),
    .wb_from_mem   (wb_from_mem),
    .ir_wr         (ir_wr),
    .pc_src        (pc_src),
    .alu_op        (alu_op),
    .alu_b_sel     (alu_b_sel),
    .alu_a_sel     (alu_a_sel),
    .reg_wr        (reg_wr),
    .dst_from_rd   (dst_from_rd)
);

// File: tb/sim_seqc_top.sv
module sim_seqc_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'b000000;

    logic       pc_wr_cond, pc_wr, addr_from_alu, mem_rd, mem_wr, wb_from_mem, ir_wr;
    logic [1:0] pc_src, alu_op, alu_b_sel;
    logic       alu_a_sel, reg_wr, dst_from_rd;

    int n_tests = 0;
    int n_fail  = 0;
    int excl_viol = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    seqc_top u0 (
        .clk           (clk),
        .rst           (rst),
        .opcode        (opcode),
        .pc_wr_cond    (pc_wr_cond),
        .pc_wr         (pc_wr),
        .addr_from_alu (addr_from_alu),
        .mem_rd        (mem_rd),
        .mem_wr        (mem_wr),
        .wb_from_mem   (wb_from_mem),
        .ir_wr         (ir_wr),
        .pc_src        (pc_src),
        .alu_op        (alu_op),
        .alu_b_sel     (alu_b_sel),
        .alu_a_sel     (alu_a_sel),
        .reg_wr        (reg_wr),
        .dst_from_rd   (dst_from_rd)
    );

    // Word layout: {pwc,pw,addr,mrd,mwr,m2r,irw,psrc[2],aop[2],bsel[2],asel,rw,rd}
    function automatic logic [15:0] mk(input logic pwc, input logic pw, input logic ad,
                                       input logic mrd, input logic mwr, input logic m2r,
                                       input logic irw, input logic [1:0] ps,
                                       input logic [1:0] ao, input logic [1:0] bs,
                                       input logic as_, input logic rw, input logic rd);
        return {pwc, pw, ad, mrd, mwr, m2r, irw, ps, ao, bs, as_, rw, rd};
    endfunction

    localparam logic [15:0] W_FETCH  = {7'b0101001, 2'b00, 2'b00, 2'b01, 3'b000};
    localparam logic [15:0] W_DECODE = {7'b0000000, 2'b00, 2'b00, 2'b11, 3'b000};
    localparam logic [15:0] W_ADDR   = {7'b0000000, 2'b00, 2'b00, 2'b10, 3'b100};
    localparam logic [15:0] W_LOAD   = {7'b0011000, 2'b00, 2'b00, 2'b00, 3'b000};
    localparam logic [15:0] W_LDWB   = {7'b0000010, 2'b00, 2'b00, 2'b00, 3'b010};
    localparam logic [15:0] W_STORE  = {7'b0010100, 2'b00, 2'b00, 2'b00, 3'b000};
    localparam logic [15:0] W_EXEC   = {7'b0000000, 2'b00, 2'b10, 2'b00, 3'b100};
    localparam logic [15:0] W_ALUWB  = {7'b0000000, 2'b00, 2'b00, 2'b00, 3'b011};
    localparam logic [15:0] W_BRANCH = {7'b1000000, 2'b01, 2'b01, 2'b00, 3'b100};
    localparam logic [15:0] W_JUMP   = {7'b0100000, 2'b10, 2'b00, 2'b00, 3'b000};

    function automatic logic [15:0] obs();
        return mk(pc_wr_cond, pc_wr, addr_from_alu, mem_rd, mem_wr, wb_from_mem, ir_wr,
                  pc_src, alu_op, alu_b_sel, alu_a_sel, reg_wr, dst_from_rd);
    endfunction

    always @(negedge clk) begin
        if (!rst && ((mem_rd && mem_wr) || (pc_wr && pc_wr_cond))) excl_viol++;
    end

    task automatic check(input logic [15:0] exp, input string req, input string what);
        logic [15:0] got;
        got = obs();
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    // Check the current word, then move one cycle on; sampling is just after the falling edge.
    task automatic step(input logic [15:0] exp, input string req, input string what);
        check(exp, req, what);
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(W_FETCH, "R1", "reset enters fetch");
    endtask

    task automatic t_load();
        opcode = 6'b100011;
        step(W_FETCH,  "R2", "load fetch");
        step(W_DECODE, "R3", "load decode");
        step(W_ADDR,   "R4", "load address");
        step(W_LOAD,   "R4", "load read");
        step(W_LDWB,   "R4", "load write-back");
        check(W_FETCH, "R4", "load back to fetch");
    endtask

    task automatic t_store();
        opcode = 6'b101011;
        step(W_FETCH,  "R2", "store fetch");
        step(W_DECODE, "R3", "store decode");
        step(W_ADDR,   "R5", "store address");
        step(W_STORE,  "R5", "store write");
        check(W_FETCH, "R5", "store back to fetch");
    endtask

    task automatic t_reg();
        opcode = 6'b000000;
        step(W_FETCH,  "R2", "reg fetch");
        step(W_DECODE, "R3", "reg decode");
        opcode = 6'b100011;   // R10: changes while executing must not matter
        check(W_EXEC,  "R10", "opcode change in execute");
        step(W_EXEC,   "R6", "reg execute");
        step(W_ALUWB,  "R6", "reg write-back");
        check(W_FETCH, "R6", "reg back to fetch");
    endtask

    task automatic t_branch();
        opcode = 6'b000100;
        step(W_FETCH,  "R2", "branch fetch");
        step(W_DECODE, "R3", "branch decode");
        opcode = 6'b101011;
        step(W_BRANCH, "R7", "branch complete");
        check(W_FETCH, "R7", "branch back to fetch");
    endtask

    task automatic t_jump();
        opcode = 6'b000010;
        step(W_FETCH,  "R2", "jump fetch");
        step(W_DECODE, "R3", "jump decode");
        step(W_JUMP,   "R8", "jump complete");
        check(W_FETCH, "R8", "jump back to fetch");
    endtask

    task automatic t_unknown();
        opcode = 6'b111111;
        step(W_FETCH,  "R2", "unknown fetch");
        step(W_DECODE, "R9", "unknown decode");
        check(W_FETCH, "R9", "unknown returns to fetch");
    endtask

    task automatic t_mid_reset();
        opcode = 6'b100011;
        step(W_FETCH,  "R2", "pre-reset fetch");
        step(W_DECODE, "R3", "pre-reset decode");
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(W_FETCH, "R1", "reset mid-instruction");
    endtask

    task automatic t_excl();
        n_tests++;
        if (excl_viol != 0) begin
            n_fail++;
            $display("FAIL R11 exclusive strobes: got %0d violations expected 0", excl_viol);
        end
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_load();
        t_store();
        t_reg();
        t_branch();
        t_jump();
        t_unknown();
        t_load();
        t_mid_reset();
        t_jump();
        t_excl();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule